// File: doc/BRIEF.md
# UART Transmit Status Flags

This block keeps the two status flags of a UART transmitter and drives the interrupt request for each. It sits between a single-byte transmit buffer, written by the host, and the transmit shift register that serializes each frame. The buffer-empty flag tells the host whether the buffer can take another byte. The transmit-complete flag tells it that the line has gone quiet: the last frame has been shifted out and nothing is waiting behind it.

The block moves each byte from the buffer to the shift register with a one-cycle load pulse. A load happens as soon as the serializer is free, and the serializer reports the end of each frame with a done pulse. A done pulse and a load may fall in the same cycle, so frames can follow each other without a gap. The complete flag is cleared when the host writes a one to it, or when its interrupt is acknowledged. Each flag drives its own interrupt request, and each request has its own enable.

Top module: `uart_txflag_ctrl`

## Requirements
- R1: After reset the buffer-empty flag is 1, the transmit-complete flag is 0, both interrupt requests are 0, the load pulse is 0 and the shift data output is 0.
- R2: A host write accepted into an empty buffer drops the buffer-empty flag at the next clock edge. If the serializer is idle, the load pulse is high in the following cycle, and at the end of that cycle the flag returns to 1 and the shift data output takes the written byte.
- R3: While a frame is in flight, a buffered byte waits. The load pulse rises combinationally in the cycle of the done pulse, so the next frame starts without an idle cycle.
- R4: A host write while the buffer holds a byte is ignored, and the buffered byte is the one later loaded.
- R5: A done pulse for a frame in flight sets the transmit-complete flag at that edge only when the buffer holds no byte. If a byte is waiting, the flag is not set.
- R6: A done pulse while no frame is in flight has no effect on the transmit-complete flag.
- R7: A status write with the complete bit at 1 clears the transmit-complete flag. A status write with the bit at 0 leaves it unchanged.
- R8: An interrupt acknowledge clears the transmit-complete flag.
- R9: When a set and a clear (a write of one or an acknowledge) arrive in the same cycle, the flag ends up set.
- R10: Each interrupt request is high exactly when its flag and its enable are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe to the transmit buffer |
| host_wdata | input | DW | Byte written to the transmit buffer |
| stat_wr | input | 1 | Host write strobe to the status register |
| stat_wdone | input | 1 | Value written to the transmit-complete bit (1 clears) |
| ser_done | input | 1 | Serializer pulse: current frame fully shifted out |
| ack_done | input | 1 | Interrupt acknowledge for transmit-complete |
| en_irq_empty | input | 1 | Enable for the buffer-empty interrupt |
| en_irq_done | input | 1 | Enable for the transmit-complete interrupt |
| ser_load | output | 1 | Load pulse moving the buffer into the shift register |
| ser_data | output | DW | Byte handed to the shift register |
| flag_empty | output | 1 | Buffer-empty flag |
| flag_done | output | 1 | Transmit-complete flag |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_done | output | 1 | Transmit-complete interrupt request |

## Verification
The hardest states to reach from the ports are the ones where a done pulse meets another event in the same cycle. These are a done pulse with a byte waiting, which gives a back-to-back load and no complete flag, and a done pulse together with a write-one clear or an acknowledge. The stimulus table first queues a second byte behind a busy serializer, so that the done pulse falls with the buffer full. It then repeats single-byte frames and places the clear-by-write and the acknowledge in exactly the cycle of the done pulse. A stray done pulse with no frame in flight is also applied, and a write is made into a full buffer, to show that both are ignored.

// File: rtl/uart_txflag_pkg.sv
package uart_txflag_pkg;

  // next value of a set/clear flag where set wins
  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  // a buffered byte may enter the serializer when it is idle or finishing
  function automatic logic may_load(logic full, logic busy, logic ending);
    return full & (~busy | ending);
  endfunction

endpackage

// File: rtl/txf_buffer.sv
module txf_buffer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] hold_data
);
  logic wr_accept;
  assign wr_accept = wr_en & ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full      <= 1'b0;
      hold_data <= '0;
    end else begin
      if (take)           full <= 1'b0;
      else if (wr_accept) full <= 1'b1;
      if (wr_accept) hold_data <= wr_data;
    end
  end

  a_r2_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !full);
  a_r4_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> $stable(hold_data));
endmodule

// File: rtl/txf_shift_track.sv
module txf_shift_track
  import uart_txflag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_full,
  input  logic [DW-1:0] buf_data,
  input  logic          ser_done,
  output logic          load,
  output logic          frame_end,
  output logic [DW-1:0] shift_data
);
  logic busy;

  assign frame_end = ser_done & busy;
  assign load      = may_load(buf_full, busy, frame_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      shift_data <= '0;
    end else begin
      if (load)           busy <= 1'b1;
      else if (frame_end) busy <= 1'b0;
      if (load) shift_data <= buf_data;
    end
  end

  a_r6_stray_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_done && !busy && !buf_full) |=> !busy);
  a_r3_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && buf_full) |=> busy);
endmodule

// File: rtl/txf_complete_flag.sv
module txf_complete_flag
  import uart_txflag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic buf_full,
  input  logic wr_clear,
  input  logic ack,
  output logic flag
);
  logic set_evt, clr_evt;

  assign set_evt = frame_end & ~buf_full;
  assign clr_evt = wr_clear | ack;

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= sticky_next(flag, set_evt, clr_evt);
  end

  a_r5_set_on_idle_end: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && clr_evt) |=> flag);
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !flag);
  a_r7_hold_without_events: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt && !set_evt && flag) |=> flag);
endmodule

// File: rtl/uart_txflag_ctrl.sv
module uart_txflag_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          stat_wr,
  input  logic          stat_wdone,
  input  logic          ser_done,
  input  logic          ack_done,
  input  logic          en_irq_empty,
  input  logic          en_irq_done,
  output logic          ser_load,
  output logic [DW-1:0] ser_data,
  output logic          flag_empty,
  output logic          flag_done,
  output logic          irq_empty,
  output logic          irq_done
);
  logic          buf_full;
  logic [DW-1:0] buf_data;
  logic          frame_end;
  logic          wr_clear;

  assign wr_clear = stat_wr & stat_wdone;

  txf_buffer #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .wr_data(host_wdata),
    .take(ser_load), .full(buf_full), .hold_data(buf_data)
  );

  txf_shift_track #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .buf_full(buf_full), .buf_data(buf_data),
    .ser_done(ser_done), .load(ser_load), .frame_end(frame_end),
    .shift_data(ser_data)
  );

  txf_complete_flag u_done (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .buf_full(buf_full),
    .wr_clear(wr_clear), .ack(ack_done), .flag(flag_done)
  );

  assign flag_empty = ~buf_full;
  assign irq_empty  = en_irq_empty & flag_empty;
  assign irq_done   = en_irq_done & flag_done;

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_empty || irq_done) |-> (en_irq_empty || en_irq_done));
  a_r7_zero_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !stat_wdone && !ack_done && flag_done) |=> flag_done);
endmodule

// File: tb/test_uart_txflag_ctrl.sv
module test_uart_txflag_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_wr, stat_wr, stat_wdone, ser_done, ack_done;
  logic       en_irq_empty, en_irq_done;
  logic [7:0] host_wdata;
  logic       ser_load, flag_empty, flag_done, irq_empty, irq_done;
  logic [7:0] ser_data;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  uart_txflag_ctrl #(.DW(8)) i_uart_txflag_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .stat_wr(stat_wr), .stat_wdone(stat_wdone), .ser_done(ser_done),
    .ack_done(ack_done), .en_irq_empty(en_irq_empty), .en_irq_done(en_irq_done),
    .ser_load(ser_load), .ser_data(ser_data), .flag_empty(flag_empty),
    .flag_done(flag_done), .irq_empty(irq_empty), .irq_done(irq_done)
  );

  typedef struct packed {
    logic       we;
    logic [7:0] dat;
    logic       swe, sclr, sdone, ack, iee, ied;
    logic       xload, xempty, xdone;
    logic [7:0] xshd;
  } vec_t;

  localparam int NV = 19;
  // fields: we dat swe sclr sdone ack iee ied | load(in cycle) empty done shd (after edge)
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00}, // idle
    '{1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // R2 write
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'hA5}, // R2 load
    '{1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5}, // R3 queue
    '{1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5}, // R4 ignored
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h3C}, // R3 R5 no set
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h3C}, // R5 set
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h3C}, // R7 zero
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C}, // R7 one, R6
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C}, // R6 stray
    '{1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h11},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h11}, // R9 ack
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h11}, // R8
    '{1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h11},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h22},
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h22}, // R9 write
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h22}, // R7 R10
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h22}  // R10
  };
  localparam string DTAG [NV] = '{
    "R1", "R2", "R2", "R3", "R4", "R5", "R5", "R7", "R7", "R6",
    "R2", "R2", "R9", "R8", "R2", "R2", "R9", "R7", "R10"
  };

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    host_wr = 1'b0; host_wdata = 8'h00; stat_wr = 1'b0; stat_wdone = 1'b0;
    ser_done = 1'b0; ack_done = 1'b0; en_irq_empty = 1'b0; en_irq_done = 1'b0;
  endtask

  task automatic check_reset_state();
    chk("R1", "flag_empty", {7'd0, flag_empty}, 8'd1);
    chk("R1", "flag_done", {7'd0, flag_done}, 8'd0);
    chk("R1", "irq_empty", {7'd0, irq_empty}, 8'd0);
    chk("R1", "irq_done", {7'd0, irq_done}, 8'd0);
    chk("R1", "ser_load", {7'd0, ser_load}, 8'd0);
    chk("R1", "ser_data", ser_data, 8'h00);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1 check_reset_state();

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      host_wr = VEC[i].we; host_wdata = VEC[i].dat;
      stat_wr = VEC[i].swe; stat_wdone = VEC[i].sclr;
      ser_done = VEC[i].sdone; ack_done = VEC[i].ack;
      en_irq_empty = VEC[i].iee; en_irq_done = VEC[i].ied;
      #1 chk("R3", "ser_load", {7'd0, ser_load}, {7'd0, VEC[i].xload});
      @(posedge clk);
      #2;
      chk("R2", "flag_empty", {7'd0, flag_empty}, {7'd0, VEC[i].xempty});
      chk(DTAG[i], "flag_done", {7'd0, flag_done}, {7'd0, VEC[i].xdone});
      chk("R4", "ser_data", ser_data, VEC[i].xshd);
      chk("R10", "irq_empty", {7'd0, irq_empty}, {7'd0, VEC[i].iee & VEC[i].xempty});
      chk("R10", "irq_done", {7'd0, irq_done}, {7'd0, VEC[i].ied & VEC[i].xdone});
    end

    // R1: reset in the middle of a queued transfer
    @(negedge clk);
    idle_inputs();
    host_wr = 1'b1; host_wdata = 8'h5A;
    @(negedge clk);
    host_wr = 1'b0;
    ser_done = 1'b0;
    @(negedge clk);
    host_wr = 1'b1; host_wdata = 8'h6B;
    @(negedge clk);
    host_wr = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1 check_reset_state();

    // R6: stray done right after reset leaves complete flag low
    @(negedge clk);
    ser_done = 1'b1;
    @(posedge clk);
    #2 chk("R6", "flag_done", {7'd0, flag_done}, 8'd0);
    @(negedge clk);
    ser_done = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule